// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block produces the low-order address bits of a four-beat burst for a synchronous burst memory. When an address strobe is accepted, it captures a starting offset. It also captures the ordering to use for that burst. On each later clock edge where the active-low advance input is low, it steps to the next beat. While advance is high it holds, so the burst is suspended without losing its place.

Two orderings are available. Interleaved order (mode high) takes the start offset XOR the beat count. Linear order (mode low) adds the beat count to the start offset and wraps modulo four. The ordering is captured together with the start offset, so a burst in progress keeps its order even if the mode input changes. After the fourth beat, further advances repeat the same cycle from the start offset.

The outputs are the current offset and the beat index. Both come straight from registers through a small mapping stage. A load or an advance sampled on an edge is therefore visible right after that edge.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, offset_o and beat_o are both 0.
- R2: When load_i is sampled high on a rising edge, offset_o equals the sampled start_i and beat_o equals 0 after that edge.
- R3: On an edge where load_i is high, adv_n_i is ignored: beat_o is 0 after the edge even when adv_n_i is low.
- R4: On an edge with load_i low and adv_n_i low, beat_o increases by one, modulo 4.
- R5: On an edge with load_i low and adv_n_i high, offset_o and beat_o keep their values (burst suspended).
- R6: With mode_i = 1 at load (interleaved), offset_o = start XOR beat_o. From start 01 the offsets run 01, 00, 11, 10. From start 10 they run 10, 11, 00, 01.
- R7: With mode_i = 0 at load (linear), offset_o = (start + beat_o) mod 4. From start 01 the offsets run 01, 10, 11, 00. From start 11 they run 11, 00, 01, 10.
- R8: An advance from beat 3 returns beat_o to 0 and offset_o to the start offset, and the pattern then repeats.
- R9: mode_i is captured only on a load edge; changing it during a burst does not change that burst's ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address strobe accepted: load a new start offset |
| start_i | input | OFS_W | Starting offset of the burst |
| adv_n_i | input | 1 | Active-low advance; high suspends the burst |
| mode_i | input | 1 | Ordering for the next burst: 1 interleaved, 0 linear |
| offset_o | output | OFS_W | Current burst offset |
| beat_o | output | OFS_W | Index of the current beat within the burst |

## Verification
The case that is hardest to bring about is an ordering change in the middle of a burst. The mode input must flip while advances continue, and the offsets must still follow the ordering that was captured at load. The stimulus loads a burst in one mode, toggles mode_i on the following advance edges, and then checks the offsets. It does this in both directions. A load with advance held low checks that advance is ignored on a load edge. Advancing past the fourth beat checks the wrap back to the start offset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             adv_n_i,
  input  logic             mode_i,
  output logic [OFS_W-1:0] start_q,
  output logic [OFS_W-1:0] beat_q,
  output order_e           order_q
);
  logic             en;
  logic [OFS_W-1:0] start_d;
  logic [OFS_W-1:0] beat_d;
  order_e           order_d;

  // Update on a load, or on an advance outside a load
  assign en = load_i | ~adv_n_i;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    order_d = order_q;
    if (load_i) begin
      start_d = start_i;
      beat_d  = '0;
      order_d = order_e'(mode_i);
    end else if (!adv_n_i) begin
      beat_d  = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (en) begin
      start_q <= start_d;
      beat_q  <= beat_d;
      order_q <= order_d;
    end
  end
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_q,
  input  logic [OFS_W-1:0] beat_q,
  input  order_e           order_q,
  output logic [OFS_W-1:0] offset_o
);
  logic [OFS_W-1:0] ilv;
  logic [OFS_W-1:0] lin;

  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv[b] = start_q[b] ^ beat_q[b];
  end

  assign lin = start_q + beat_q;

  always_comb begin
    offset_o = (order_q == ORD_INTERLEAVE) ? ilv : lin;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             adv_n_i,
  input  logic             mode_i,
  output logic [OFS_W-1:0] offset_o,
  output logic [OFS_W-1:0] beat_o
);
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  order_e           order_q;

  burst_seq_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .start_q (start_q),
    .beat_q  (beat_q),
    .order_q (order_q)
  );

  burst_seq_map #(.OFS_W(OFS_W)) u_map (
    .start_q  (start_q),
    .beat_q   (beat_q),
    .order_q  (order_q),
    .offset_o (offset_o)
  );

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [OFS_W-1:0] start_i,
  input logic             adv_n_i,
  input logic [OFS_W-1:0] offset_o,
  input logic [OFS_W-1:0] beat_o
);
  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (offset_o == $past(start_i) && beat_o == '0));

  // R3
  load_ignores_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_n_i) |=> (beat_o == '0));

  // R4
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> (beat_o == OFS_W'($past(beat_o) + 1'b1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ($stable(offset_o) && $stable(beat_o)));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && (&beat_o)) |=> (beat_o == '0));
endmodule

bind burst_seq burst_seq_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .start_i  (start_i),
  .adv_n_i  (adv_n_i),
  .offset_o (offset_o),
  .beat_o   (beat_o)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
  logic       clk;
  logic       rst_n;
  logic       load_i;
  logic [1:0] start_i;
  logic       adv_n_i;
  logic       mode_i;
  logic [1:0] offset_o;
  logic [1:0] beat_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [1:0] off;
    logic [1:0] beat;
    string      tag;
  } exp_t;

  exp_t sb[$];

  burst_seq #(.OFS_W(2)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .start_i  (start_i),
    .adv_n_i  (adv_n_i),
    .mode_i   (mode_i),
    .offset_o (offset_o),
    .beat_o   (beat_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Drive one cycle of inputs and record what the outputs must show after the edge
  task automatic step(input logic ld, input logic [1:0] st, input logic advn,
                      input logic md, input logic [1:0] eo, input logic [1:0] eb,
                      input string tag);
    exp_t e;
    @(negedge clk);
    load_i  = ld;
    start_i = st;
    adv_n_i = advn;
    mode_i  = md;
    @(posedge clk);
    #1;
    e.off  = eo;
    e.beat = eb;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (offset_o !== e.off || beat_o !== e.beat) begin
        bad++;
        $display("FAIL %s: offset=%b beat=%0d expected offset=%b beat=%0d",
                 e.tag, offset_o, beat_o, e.off, e.beat);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    load_i  = 1'b0;
    start_i = 2'b00;
    adv_n_i = 1'b1;
    mode_i  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (offset_o !== 2'b00 || beat_o !== 2'b00) begin
      bad++;
      $display("FAIL R1: offset=%b beat=%0d expected offset=00 beat=0", offset_o, beat_o);
    end
    rst_n = 1'b1;
    step(0, 2'b11, 1, 0, 2'b00, 2'd0, "R1 after release");

    // Interleaved from 01, then past the fourth beat
    step(1, 2'b01, 1, 1, 2'b01, 2'd0, "R2 load ilv 01");
    step(0, 2'b00, 0, 1, 2'b00, 2'd1, "R6 ilv beat1");
    step(0, 2'b00, 0, 1, 2'b11, 2'd2, "R6 ilv beat2");
    step(0, 2'b00, 0, 1, 2'b10, 2'd3, "R6 ilv beat3");
    step(0, 2'b00, 0, 1, 2'b01, 2'd0, "R8 ilv wrap");
    step(0, 2'b00, 0, 1, 2'b00, 2'd1, "R8 ilv repeat");

    // Interleaved from 10
    step(1, 2'b10, 1, 1, 2'b10, 2'd0, "R2 load ilv 10");
    step(0, 2'b00, 0, 1, 2'b11, 2'd1, "R6 ilv10 beat1");
    step(0, 2'b00, 0, 1, 2'b00, 2'd2, "R6 ilv10 beat2");
    step(0, 2'b00, 0, 1, 2'b01, 2'd3, "R6 ilv10 beat3");

    // Linear from 01
    step(1, 2'b01, 1, 0, 2'b01, 2'd0, "R2 load lin 01");
    step(0, 2'b00, 0, 0, 2'b10, 2'd1, "R7 lin beat1");
    step(0, 2'b00, 0, 0, 2'b11, 2'd2, "R7 lin beat2");
    step(0, 2'b00, 0, 0, 2'b00, 2'd3, "R7 lin beat3");

    // Linear from 11 with wrap
    step(1, 2'b11, 1, 0, 2'b11, 2'd0, "R2 load lin 11");
    step(0, 2'b00, 0, 0, 2'b00, 2'd1, "R7 lin11 beat1");
    step(0, 2'b00, 0, 0, 2'b01, 2'd2, "R7 lin11 beat2");
    step(0, 2'b00, 0, 0, 2'b10, 2'd3, "R7 lin11 beat3");
    step(0, 2'b00, 0, 0, 2'b11, 2'd0, "R8 lin11 wrap");

    // Advance low on a load edge is ignored
    step(1, 2'b10, 0, 0, 2'b10, 2'd0, "R3 load with adv");

    // Suspend and resume
    step(0, 2'b01, 1, 0, 2'b10, 2'd0, "R5 hold a");
    step(0, 2'b11, 1, 1, 2'b10, 2'd0, "R5 hold b");
    step(0, 2'b00, 0, 0, 2'b11, 2'd1, "R4 resume");
    step(0, 2'b00, 1, 0, 2'b11, 2'd1, "R5 hold mid");
    step(0, 2'b00, 0, 0, 2'b00, 2'd2, "R4 step again");

    // Mode change mid burst: interleaved burst keeps its order
    step(1, 2'b01, 1, 1, 2'b01, 2'd0, "R9 load ilv");
    step(0, 2'b00, 0, 0, 2'b00, 2'd1, "R9 ilv kept 1");
    step(0, 2'b00, 0, 0, 2'b11, 2'd2, "R9 ilv kept 2");
    // Linear burst keeps its order
    step(1, 2'b01, 1, 0, 2'b01, 2'd0, "R9 load lin");
    step(0, 2'b00, 0, 1, 2'b10, 2'd1, "R9 lin kept 1");
    step(0, 2'b00, 0, 1, 2'b11, 2'd2, "R9 lin kept 2");

    step(0, 2'b00, 1, 0, 2'b11, 2'd2, "R5 final hold");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule